// File: doc/BRIEF.md
# Register File with Stack-Aliased Index

This block is a general-purpose register file with two combinational read ports and one synchronous write port. One fixed register index does not address normal storage. It is an alias for a small internal last-in-first-out stack, which software typically uses to hold return addresses. Writing that index pushes the write data. Reading it returns the current top entry, and a read port can also pop that entry when its pop strobe is set. Every other index behaves like an ordinary register, and index 0 always reads as zero.

An error vector can arrive late in the cycle and carries several independent categories. If any bit is set, no push or pop takes effect in that cycle. The error term, together with the overflow and underflow conditions, drives only the stack's pointer and entry write enables. The read-data select for each port is decoded from that port's index alone. A slow error therefore never lies on the path from the register storage to the read data. Overflow and underflow are reported as same-cycle flags. All ports are plain control and data pins with no handshake. Every access completes in its own cycle, so there is no back-pressure.

Top module: `rf_stack_alias`

## Requirements
- R1: A read of the stack index (1) returns the most recently pushed entry that is still held, or zero when the stack is empty.
- R2: A write to an index from 2 to 31 with `wr_en` high stores `wr_data`, and the stored value is visible on both read ports from the next rising clock edge onward.
- R3: A write to index 0 has no effect, and a read of index 0 always returns zero.
- R4: A write to index 1 pushes. A read of index 1 with its port's pop strobe high pops. When both read ports pop in the same cycle, the stack pops only one entry.
- R5: A push and a pop in the same cycle on a non-empty stack replace the top entry, and the depth is unchanged.
- R6: If any bit of `err_in` is set, the stack depth and contents do not change in that cycle. Ordinary register writes still take place.
- R7: A push without a pop while the stack holds 8 entries raises `stk_ovf` in that cycle, and the stack does not change.
- R8: A pop while the stack is empty raises `stk_unf` in that cycle, and the stack does not change, even if a push is also requested.
- R9: Read data of the stack index in a cycle with `err_in` set is still the current top entry. The read select does not depend on the error vector.
- R10: A pop strobe on a read port whose index is not 1 has no effect on the stack.
- R11: A synchronous active-high `rst` clears all registers and empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A index |
| ra_pop | input | 1 | Port A pops when its index is the stack index |
| ra_data | output | 32 | Port A read data (combinational) |
| rb_idx | input | 5 | Read port B index |
| rb_pop | input | 1 | Port B pops when its index is the stack index |
| rb_data | output | 32 | Port B read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| err_in | input | 4 | Error categories; any set bit cancels stack updates |
| stk_ovf | output | 1 | Push attempted on a full stack (combinational) |
| stk_unf | output | 1 | Pop attempted on an empty stack (combinational) |

## Verification
Read data and the overflow and underflow flags are combinational, so they are due in the same cycle as the index and strobes that cause them. Register writes and stack changes are due one rising edge later. The bench applies inputs on the falling edge. It compares every output against a queue-based model midway through the low phase, and it updates the model only at the following rising edge. Each check therefore sees the state left by all earlier cycles plus this cycle's combinational result.

// File: rtl/rf_stack_pkg.sv
package rf_stack_pkg;
  // Stack request for one cycle, built from index decode and strobes only.
  typedef struct packed {
    logic push;
    logic pop;
  } stk_req_t;

  localparam int unsigned N_RD_PORTS = 2;
endpackage

// File: rtl/rf_port_decode.sv
module rf_port_decode #(
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned STACK_IDX = 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic             is_stk,
  output logic             is_zero
);
  // Pure index decode: never sees the error vector.
  always_comb begin
    is_stk  = (idx == IDX_W'(STACK_IDX));
    is_zero = (idx == '0);
  end
endmodule

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned NRD    = 2,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] regs_q [NREGS];

  // Slot 0 is hard-wired to zero; the rest are flops with their own enable.
  assign regs_q[0] = '0;

  for (genvar r = 1; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[r] <= '0;
      else if (wr_en && wr_idx == IDX_W'(r))
        regs_q[r] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = regs_q[rd_idx[p]];

    // R3: index 0 reads as zero on every port
    a_r3_zero_read: assert property (@(posedge clk) disable iff (rst)
      (rd_idx[p] == '0) |-> (rd_data[p] == '0));
  end

  // R2: a write to a nonzero slot is visible on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/rf_hw_stack.sv
module rf_hw_stack #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1),
  localparam int unsigned SLT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rf_stack_pkg::stk_req_t  req,
  input  logic [DATA_W-1:0]       push_data,
  input  logic                    abort,
  output logic [DATA_W-1:0]       top,
  output logic                    ovf,
  output logic                    unf
);
  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [PTR_W-1:0]  depth_q;
  logic              empty, full, commit;
  logic [SLT_W-1:0]  top_slot, free_slot;
  logic              ptr_inc, ptr_dec, wr_top, wr_free;

  always_comb begin
    empty     = (depth_q == '0);
    full      = (depth_q == PTR_W'(DEPTH));
    top_slot  = SLT_W'(depth_q - 1'b1);
    free_slot = SLT_W'(depth_q);
    top       = empty ? '0 : ent_q[top_slot];
    ovf       = req.push && !req.pop && full;
    unf       = req.pop && empty;
    // "action actually happens": only feeds the flop enables below
    commit    = !abort && !ovf && !unf;
    ptr_inc   = commit && req.push && !req.pop;
    ptr_dec   = commit && req.pop && !req.push;
    wr_free   = ptr_inc;
    wr_top    = commit && req.push && req.pop;
  end

  always_ff @(posedge clk) begin
    if (rst)
      depth_q <= '0;
    else if (ptr_inc)
      depth_q <= depth_q + 1'b1;
    else if (ptr_dec)
      depth_q <= depth_q - 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent_q[e] <= '0;
      else if ((wr_free && free_slot == SLT_W'(e)) ||
               (wr_top && top_slot == SLT_W'(e)))
        ent_q[e] <= push_data;
    end
  end

  // R6: an error freezes depth and top
  a_r6_abort_freezes: assert property (@(posedge clk) disable iff (rst)
    abort |=> ($stable(depth_q) && $stable(top)));
  // R7: overflow leaves the stack untouched
  a_r7_ovf_holds: assert property (@(posedge clk) disable iff (rst)
    ovf |=> $stable(depth_q));
  // R8: underflow leaves the stack untouched
  a_r8_unf_holds: assert property (@(posedge clk) disable iff (rst)
    unf |=> (depth_q == '0));
  // R4: a clean push grows the stack and exposes the pushed word
  a_r4_push_grows: assert property (@(posedge clk) disable iff (rst)
    (req.push && !req.pop && !abort && !full) |=>
      (depth_q == $past(depth_q) + 1'b1 && top == $past(push_data)));
  // R5: push with pop keeps depth and replaces the top
  a_r5_replace: assert property (@(posedge clk) disable iff (rst)
    (req.push && req.pop && !abort && !empty) |=>
      ($stable(depth_q) && top == $past(push_data)));
  // R1: empty stack reads zero
  a_r1_empty_zero: assert property (@(posedge clk) disable iff (rst)
    empty |-> (top == '0));
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth_q <= PTR_W'(DEPTH));
endmodule

// File: rtl/rf_stack_alias.sv
module rf_stack_alias #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NREGS     = 32,
  parameter int unsigned STACK_IDX = 1,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned ERR_W     = 4,
  localparam int unsigned IDX_W    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic              ra_pop,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic              rb_pop,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  err_in,
  output logic              stk_ovf,
  output logic              stk_unf
);
  import rf_stack_pkg::*;

  localparam int unsigned NPORT = N_RD_PORTS + 1; // reads then write

  logic [NPORT-1:0][IDX_W-1:0] port_idx;
  logic [NPORT-1:0]            port_stk, port_zero;
  logic [N_RD_PORTS-1:0]       rd_pop;
  logic [N_RD_PORTS-1:0][IDX_W-1:0]  bank_idx;
  logic [N_RD_PORTS-1:0][DATA_W-1:0] bank_rd, rd_out;
  logic [DATA_W-1:0]           stk_top;
  logic                        bank_we, any_err;
  stk_req_t                    req;

  assign port_idx = {wr_idx, rb_idx, ra_idx};
  assign rd_pop   = {rb_pop, ra_pop};
  assign bank_idx = {rb_idx, ra_idx};

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    rf_port_decode #(.IDX_W(IDX_W), .STACK_IDX(STACK_IDX)) u_dec (
      .idx    (port_idx[p]),
      .is_stk (port_stk[p]),
      .is_zero(port_zero[p])
    );
  end

  // Requests come from decode and strobes; the error stays out of them.
  always_comb begin
    req.push = wr_en && port_stk[N_RD_PORTS];
    req.pop  = |(rd_pop & port_stk[N_RD_PORTS-1:0]);
    bank_we  = wr_en && !port_stk[N_RD_PORTS] && !port_zero[N_RD_PORTS];
    any_err  = |err_in;
  end

  rf_gpr_bank #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(N_RD_PORTS)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bank_we),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (bank_idx),
    .rd_data(bank_rd)
  );

  rf_hw_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .push_data(wr_data),
    .abort    (any_err),
    .top      (stk_top),
    .ovf      (stk_ovf),
    .unf      (stk_unf)
  );

  // Read mux: select is the index decode alone.
  for (genvar p = 0; p < N_RD_PORTS; p++) begin : g_mux
    assign rd_out[p] = port_stk[p] ? stk_top : bank_rd[p];
  end

  assign ra_data = rd_out[0];
  assign rb_data = rd_out[1];

  // R10: pop strobes on other indices never request a pop
  a_r10_stray_pop: assert property (@(posedge clk) disable iff (rst)
    (ra_idx != IDX_W'(STACK_IDX) && rb_idx != IDX_W'(STACK_IDX)) |-> !stk_unf);
  // R9: both ports on the stack index agree, error or not
  a_r9_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == rb_idx) |-> (ra_data == rb_data));
  // R11: reset leaves every read at zero
  a_r11_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (ra_data == '0 && rb_data == '0));
endmodule

// File: tb/rf_stack_alias_tb_top.sv
module rf_stack_alias_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  ra_idx, rb_idx, wr_idx;
  logic        ra_pop, rb_pop, wr_en;
  logic [31:0] wr_data, ra_data, rb_data;
  logic [3:0]  err_in;
  logic        stk_ovf, stk_unf;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_regs [32];
  logic [31:0] m_stk [$];

  always #10 clk = ~clk; // 50 MHz

  rf_stack_alias dut_i (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .ra_pop(ra_pop), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_pop(rb_pop), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .err_in(err_in), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  function automatic logic [31:0] exp_rd(input logic [4:0] i);
    if (i == 5'd0) return 32'd0;
    if (i == 5'd1) return (m_stk.size() > 0) ? m_stk[$] : 32'd0;
    return m_regs[i];
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Inputs already driven after a falling edge; check mid-low, then update model at rising edge.
  task automatic step(input string tag);
    logic push, pop, ovf, unf, ok;
    #5;
    push = wr_en && wr_idx == 5'd1;
    pop  = (ra_pop && ra_idx == 5'd1) || (rb_pop && rb_idx == 5'd1);
    ovf  = push && !pop && m_stk.size() == 8;
    unf  = pop && m_stk.size() == 0;
    cmp(tag, "ra_data", ra_data, exp_rd(ra_idx));
    cmp(tag, "rb_data", rb_data, exp_rd(rb_idx));
    cmp(tag, "stk_ovf", {31'd0, stk_ovf}, {31'd0, ovf});
    cmp(tag, "stk_unf", {31'd0, stk_unf}, {31'd0, unf});
    @(posedge clk);
    ok = (err_in == 4'd0) && !ovf && !unf;
    if (ok) begin
      if (push && pop) m_stk[m_stk.size()-1] = wr_data;
      else if (push) m_stk.push_back(wr_data);
      else if (pop) void'(m_stk.pop_back());
    end
    if (wr_en && wr_idx > 5'd1) m_regs[wr_idx] = wr_data;
    @(negedge clk);
    ra_pop = 1'b0; rb_pop = 1'b0; wr_en = 1'b0; err_in = 4'd0;
  endtask

  task automatic rd(input logic [4:0] a, input logic pa, input logic [4:0] b, input logic pb);
    ra_idx = a; ra_pop = pa; rb_idx = b; rb_pop = pb;
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0; err_in = 0;
    rd(0, 0, 0, 0);
    for (int i = 0; i < 32; i++) m_regs[i] = 32'd0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R11: everything reads zero after reset
    rd(5, 0, 1, 0); step("R11");
    rd(31, 0, 2, 0); step("R11");

    // R2: ordinary writes and readback on both ports
    for (int i = 2; i < 8; i++) begin wr(i[4:0], 32'hA000_0000 + i); rd(2, 0, 3, 0); step("R2"); end
    rd(6, 0, 7, 0); step("R2");

    // R3: write to index 0 ignored
    wr(0, 32'hDEAD_BEEF); rd(0, 0, 0, 0); step("R3");
    rd(0, 0, 4, 0); step("R3");

    // R1/R4: pushes and top reads, pop via port B
    wr(1, 32'h1111); rd(1, 0, 1, 0); step("R4");
    wr(1, 32'h2222); rd(1, 0, 2, 0); step("R4");
    wr(1, 32'h3333); rd(1, 0, 1, 0); step("R1");
    rd(3, 0, 1, 1); step("R4");
    rd(1, 0, 1, 0); step("R1");
    // R4: both ports pop together -> one pop
    rd(1, 1, 1, 1); step("R4");
    rd(1, 0, 0, 0); step("R4");

    // R5: push and pop at once replace top
    wr(1, 32'h5555); rd(1, 1, 1, 0); step("R5");
    rd(1, 0, 1, 0); step("R5");

    // R6/R9: error blocks stack update, reads still show top, regs still written
    wr(1, 32'h6666); err_in = 4'b0100; rd(1, 0, 1, 0); step("R9");
    rd(1, 1, 5, 0); err_in = 4'b1001; step("R6");
    wr(9, 32'h9999); err_in = 4'b0010; rd(1, 0, 9, 0); step("R6");
    rd(1, 0, 9, 0); step("R6");

    // R10: pop strobes on other indices do nothing
    rd(2, 1, 3, 1); step("R10");
    rd(1, 0, 1, 0); step("R10");

    // R7: fill to 8 then overflow
    for (int i = 0; i < 8; i++) begin wr(1, 32'hC000_0000 + i); rd(1, 0, 0, 0); step("R7"); end
    wr(1, 32'hFFFF_0000); rd(1, 0, 1, 0); step("R7");
    rd(1, 0, 1, 0); step("R7");
    // full stack: push with pop still replaces (R5)
    wr(1, 32'h7777); rd(1, 1, 0, 0); step("R5");

    // R8: drain then underflow (with push too)
    for (int i = 0; i < 8; i++) begin rd(1, 1, 1, 0); step("R8"); end
    rd(1, 1, 1, 0); step("R8");
    wr(1, 32'h8888); rd(1, 0, 1, 1); step("R8");
    rd(1, 0, 1, 0); step("R1");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 1) == 1) wr(5'($urandom_range(0, 5)), $urandom);
      rd(5'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
         5'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 5) == 0) err_in = 4'($urandom_range(1, 15));
      step("R4");
    end

    // R11: reset mid-run clears
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_stk.delete();
    for (int i = 0; i < 32; i++) m_regs[i] = 32'd0;
    rd(1, 0, 2, 0); step("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule